// File: doc/BRIEF.md
# Complementary Output Short-Circuit Guard

This block protects a motor or power stage driven by complementary timer outputs. It watches three pin pairs. Each pair carries the high-side and low-side outputs of one timer channel. If both pins of an enabled pair drive their active level at the same sampled clock edge, the power stage would see a shoot-through. The guard then latches a fault and takes all six pins of its timer unit to high impedance.

A polarity input selects the active level: low or high. Each pin also carries a function-select code, and the level check runs only for pins that are set up as real output drives. A small write/read port holds the per-pair enables and the interrupt enable, and it exposes the fault flag. Software clears the flag with a read-then-write sequence. Each timer unit gets its own instance, and each instance has its own polarity input.

Top module: `pair_short_guard`

## Requirements
- R1: After reset the fault flag is 0, all six output enables are 1 (pins released), the interrupt request is 0 and the readback word is 0.
- R2: With polarity 0 a pin is active when it is low. With polarity 1 a pin is active when it is high. Two pins at the inactive level never trip the guard.
- R3: If both pins of an enabled, checked pair are active at a rising clock edge, the fault flag is 1 after that edge. A single active pin does not trip the guard.
- R4: Each pin has a 2-bit function code in `pin_func[2i+1:2i]`. Code 01 (timer output) and code 10 (general output) are checked. Codes 00 and 11 are not checked, and a pair with any unchecked pin never trips.
- R5: A pair whose enable bit is 0 never trips, whatever its pin levels.
- R6: While the fault flag is 1, all six `pin_oe` bits are 0 (high impedance), not only the offending pair.
- R7: The fault flag stays 1 after the overlap goes away, until a valid clear.
- R8: A clear is a write with bit 4 = 0 that follows a read (`rd_en`) made while the flag was 1. A write without such a read is ignored. Writing bit 4 = 1 never sets the flag.
- R9: A valid clear is ignored, and the flag stays 1, if an overlap is present on the same edge.
- R10: `irq` is 1 exactly while the fault flag is 1 and the interrupt enable bit is 1.
- R11: The control word has this layout: bits [2:0] are the pair enables (bit k for pair k), bit 3 is the interrupt enable and bit 4 is the fault flag. Every write updates bits [3:0], and `rd_data` returns this word.
- R12: Pair k consists of pins 2k and 2k+1. Active pins that belong to different pairs do not trip the guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 6 | Output values the timer drives on the six pins |
| pin_func | input | 12 | Function code per pin, 2 bits each |
| pol | input | 1 | Active-level polarity (0 = low active) |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 5 | Write data: pair enables, interrupt enable, flag bit |
| rd_en | input | 1 | Read strobe; arms the clear when the flag is 1 |
| rd_data | output | 5 | Control word readback |
| pin_oe | output | 6 | Per-pin output enable, 0 = high impedance |
| fault_flag | output | 1 | Latched overlap fault |
| irq | output | 1 | Interrupt request |

## Verification
Detection of a new overlap and a software clear of the latched flag can fall on the same clock edge. In that case detection must win. The bench arms a clear with a read and then issues the clearing write while a pair still shows both pins active. It expects the flag, the high-impedance outputs and the interrupt to stay set. The next cycle repeats the write with the overlap gone and expects everything to be released.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int FUNC_W = 2;
  localparam logic [FUNC_W-1:0] FN_TIMER_OUT = 2'b01;
  localparam logic [FUNC_W-1:0] FN_GPIO_OUT  = 2'b10;

  function automatic logic pin_active(input logic lvl, input logic pol);
    return (lvl == pol);
  endfunction

  function automatic logic func_checked(input logic [FUNC_W-1:0] code);
    return (code == FN_TIMER_OUT) || (code == FN_GPIO_OUT);
  endfunction
endpackage

// File: rtl/sg_pair_cmp.sv
module sg_pair_cmp
  import sg_pkg::*;
(
  input  logic              lvl_hi,
  input  logic              lvl_lo,
  input  logic [FUNC_W-1:0] fn_hi,
  input  logic [FUNC_W-1:0] fn_lo,
  input  logic              pol,
  input  logic              en,
  output logic              hit
);
  logic both_checked;
  logic both_active;

  always_comb begin
    both_checked = func_checked(fn_hi) && func_checked(fn_lo);
    both_active  = pin_active(lvl_hi, pol) && pin_active(lvl_lo, pol);
    hit          = en && both_checked && both_active;
  end
endmodule

// File: rtl/sg_cfg_regs.sv
module sg_cfg_regs #(
  parameter int NPAIRS = 3,
  localparam int WDW = NPAIRS + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WDW-1:0]    wr_data,
  output logic [NPAIRS-1:0] pair_en,
  output logic              irq_en,
  output logic              clr_req
);
  localparam int IEN_BIT  = NPAIRS;
  localparam int FLAG_BIT = NPAIRS + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_en <= '0;
      irq_en  <= 1'b0;
    end else if (wr_en) begin
      pair_en <= wr_data[NPAIRS-1:0];
      irq_en  <= wr_data[IEN_BIT];
    end
  end

  assign clr_req = wr_en && !wr_data[FLAG_BIT];
endmodule

// File: rtl/sg_fault_latch.sv
module sg_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic overlap,
  input  logic clr_req,
  input  logic rd_en,
  output logic fault_flag,
  output logic armed,
  output logic clr_ok
);
  assign clr_ok = clr_req && armed && !overlap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_flag <= 1'b0;
      armed      <= 1'b0;
    end else begin
      fault_flag <= overlap || (fault_flag && !clr_ok);
      if (clr_ok)
        armed <= 1'b0;
      else if (rd_en && fault_flag)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/pair_short_guard.sv
module pair_short_guard
  import sg_pkg::*;
#(
  parameter int NPAIRS = 3,
  localparam int NPINS = 2 * NPAIRS,
  localparam int WDW   = NPAIRS + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        pin_lvl,
  input  logic [FUNC_W*NPINS-1:0] pin_func,
  input  logic                    pol,
  input  logic                    wr_en,
  input  logic [WDW-1:0]          wr_data,
  input  logic                    rd_en,
  output logic [WDW-1:0]          rd_data,
  output logic [NPINS-1:0]        pin_oe,
  output logic                    fault_flag,
  output logic                    irq
);
  logic [NPAIRS-1:0] pair_en;
  logic [NPAIRS-1:0] pair_hit;
  logic              irq_en;
  logic              clr_req;
  logic              clr_ok;
  logic              armed;
  logic              overlap;

  sg_cfg_regs #(.NPAIRS(NPAIRS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pair_en(pair_en), .irq_en(irq_en), .clr_req(clr_req)
  );

  for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
    sg_pair_cmp u_cmp (
      .lvl_hi(pin_lvl[2*k]),
      .lvl_lo(pin_lvl[2*k+1]),
      .fn_hi (pin_func[FUNC_W*(2*k)   +: FUNC_W]),
      .fn_lo (pin_func[FUNC_W*(2*k+1) +: FUNC_W]),
      .pol   (pol),
      .en    (pair_en[k]),
      .hit   (pair_hit[k])
    );
  end

  assign overlap = |pair_hit;

  sg_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n), .overlap(overlap), .clr_req(clr_req),
    .rd_en(rd_en), .fault_flag(fault_flag), .armed(armed), .clr_ok(clr_ok)
  );

  assign pin_oe  = {NPINS{!fault_flag}};
  assign irq     = fault_flag && irq_en;
  assign rd_data = {fault_flag, irq_en, pair_en};
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk #(
  parameter int NPAIRS = 3,
  localparam int NPINS = 2 * NPAIRS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPAIRS-1:0] pair_en,
  input logic [NPAIRS-1:0] pair_hit,
  input logic              overlap,
  input logic              clr_req,
  input logic              armed,
  input logic              fault_flag,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq
);
  AST_OVERLAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |=> fault_flag); // R3
  AST_ROSE_NEEDS_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> $past(overlap)); // R3
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_hit & ~pair_en) == '0); // R5
  AST_HIZ_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != {NPINS{1'b1}}) |-> fault_flag); // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !(clr_req && armed)) |=> fault_flag); // R7
  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_flag) |-> $past(clr_req && armed && !overlap)); // R8
  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && overlap) |=> fault_flag); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fault_flag); // R10
endmodule

bind pair_short_guard sg_guard_chk #(.NPAIRS(NPAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pair_en(pair_en), .pair_hit(pair_hit),
  .overlap(overlap), .clr_req(clr_req), .armed(armed),
  .fault_flag(fault_flag), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/pair_short_guard_bench.sv
module pair_short_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  pin_lvl = 6'h15;
  logic [11:0] pin_func = 12'h555;
  logic        pol = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_data;
  logic [5:0]  pin_oe;
  logic        fault_flag;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk; // 125 MHz

  pair_short_guard u_pair_short_guard (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_func(pin_func),
    .pol(pol), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .pin_oe(pin_oe), .fault_flag(fault_flag), .irq(irq)
  );

  // monitor: one expected item per cycle, compared away from the rising edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [12:0] e;
      logic [12:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {fault_flag, pin_oe, irq, rd_data};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual flag/oe/irq/rd=%h expected=%h", t, a, e);
      end
    end
  end

  // driver: apply one cycle of stimulus and push what must follow the edge
  task automatic cyc(input logic [5:0] lvl, input logic [11:0] fn, input logic p,
                     input logic we, input logic [4:0] wd, input logic re,
                     input logic ef, input logic [5:0] eoe, input logic ei,
                     input logic [4:0] erd, input string tag);
    @(negedge clk); #1;
    pin_lvl = lvl; pin_func = fn; pol = p;
    wr_en = we; wr_data = wd; rd_en = re;
    exp_q.push_back({ef, eoe, ei, erd});
    tag_q.push_back(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    //  lvl    func     pol  we  wd     re  flag oe     irq rd
    cyc(6'h15, 12'h555, 0,   0, 5'h00, 0,  0, 6'h3F, 0, 5'h00, "R1 reset state");
    cyc(6'h15, 12'h555, 0,   1, 5'h0F, 0,  0, 6'h3F, 0, 5'h0F, "R11 enable write");
    cyc(6'h1D, 12'h555, 0,   0, 5'h00, 0,  0, 6'h3F, 0, 5'h0F, "R2 inactive high pair pol0");
    cyc(6'h14, 12'h554, 0,   0, 5'h00, 0,  0, 6'h3F, 0, 5'h0F, "R4 code 00 unchecked");
    cyc(6'h14, 12'h557, 0,   0, 5'h00, 0,  0, 6'h3F, 0, 5'h0F, "R4 code 11 unchecked");
    cyc(6'h19, 12'h555, 0,   0, 5'h00, 0,  0, 6'h3F, 0, 5'h0F, "R12 cross-pair lows");
    cyc(6'h14, 12'h556, 0,   0, 5'h00, 0,  1, 6'h00, 1, 5'h1F, "R3 R6 trip gpio+timer");
    cyc(6'h15, 12'h555, 0,   0, 5'h00, 0,  1, 6'h00, 1, 5'h1F, "R7 latched after overlap");
    cyc(6'h15, 12'h555, 0,   1, 5'h0F, 0,  1, 6'h00, 1, 5'h1F, "R8 write without read");
    cyc(6'h15, 12'h555, 0,   0, 5'h00, 1,  1, 6'h00, 1, 5'h1F, "R8 arming read");
    cyc(6'h14, 12'h555, 0,   1, 5'h0F, 0,  1, 6'h00, 1, 5'h1F, "R9 clear during overlap");
    cyc(6'h15, 12'h555, 0,   1, 5'h0F, 0,  0, 6'h3F, 0, 5'h0F, "R8 valid clear");
    cyc(6'h15, 12'h555, 0,   1, 5'h0B, 0,  0, 6'h3F, 0, 5'h0B, "R11 disable pair2");
    cyc(6'h05, 12'h555, 0,   0, 5'h00, 0,  0, 6'h3F, 0, 5'h0B, "R5 disabled pair");
    cyc(6'h1D, 12'h555, 1,   0, 5'h00, 0,  1, 6'h00, 1, 5'h1B, "R2 pol1 high trip");
    cyc(6'h15, 12'h555, 1,   1, 5'h03, 0,  1, 6'h00, 0, 5'h13, "R10 irq masked");
    cyc(6'h15, 12'h555, 1,   0, 5'h00, 1,  1, 6'h00, 0, 5'h13, "R8 arming read 2");
    cyc(6'h15, 12'h555, 1,   1, 5'h0B, 0,  0, 6'h3F, 0, 5'h0B, "R10 clear with irq on");
    cyc(6'h14, 12'h555, 1,   0, 5'h00, 0,  0, 6'h3F, 0, 5'h0B, "R2 pol1 lows inactive");
    cyc(6'h15, 12'h555, 1,   1, 5'h1B, 0,  0, 6'h3F, 0, 5'h0B, "R8 writing 1 never sets");
    cyc(6'h14, 12'h555, 0,   0, 5'h00, 0,  1, 6'h00, 1, 5'h1B, "R10 irq with enable");
    @(negedge clk); #1 wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule